// File: doc/BRIEF.md
# Channel-Associated Signalling Serial Stream Interface

This block moves four-bit ABCD signalling nibbles between per-channel storage and a pair of 2.048 Mbit/s serial streams. A frame has 32 timeslots of 8 bits, 256 bit periods, and one clock period of `clk` is one bit period. An active-low frame pulse on `fp_n` aligns the frame. On the outgoing stream, the nibbles of 30 voice channels are written by the line side into a small store and shifted out MSB first. On the incoming stream, 30 nibbles are captured from the serial input and made readable. A frame's nibbles only become readable once that whole frame has been captured.

Each timeslot carries its nibble in one half only. `half_sel_hi` chooses which half. On the output, the other half is not driven, and `sig_oe` marks exactly the driven periods. On the input, the other half is ignored. Timeslots 0 and 16 never carry a signalling nibble.

A common-channel mode replaces both streams with the 64 kb/s bit stream of timeslot 16. A bypass control stops the serial input from updating anything. All three controls are taken at the start of a frame and held for the whole frame.

Top module: `sigstr_cas_if`

## Requirements
- R1: While `rst` is high, and after it until the first frame pulse, `sig_oe` and `sig_o` are 0; `ccs_rx_byte` resets to 0.
- R2: When `fp_n` is low at a rising `clk` edge, the next clock period is bit period 0 of timeslot 0. Bit period b of timeslot t is period 8t+b, with 256 periods per frame and the first-sent bit being the most significant. Without a new pulse the count wraps to period 0 after period 255.
- R3: In signalling mode, the stored nibble of channel c (0 to 29) is sent in timeslot c+1 for c<15 and in timeslot c+2 for c>=15, with nibble bit 3 first. Timeslots 0 and 16 have `sig_oe`=0 throughout.
- R4: With `half_sel_hi`=1, only bit periods 0 to 3 of a signalling timeslot are driven. With `half_sel_hi`=0, only bit periods 4 to 7 are driven. The other four periods have `sig_oe`=0.
- R5: `sig_o` is 0 in every period where `sig_oe` is 0.
- R6: `sig_i` is sampled once per bit period. In each signalling timeslot, the four bits of the selected half form that channel's nibble, with the first one received becoming bit 3. The other half and timeslots 0 and 16 have no effect on the captured nibbles.
- R7: Captured nibbles become readable only after the last bit period of their frame. `rd_nib` shows the readable nibble of channel `rd_ch` one clock after `rd_ch` is applied. During the next frame's capture, `rd_nib` keeps the previous frame's value. A frame cut short by an early frame pulse is never made readable.
- R8: With `serial_off`=1, nothing from `sig_i` becomes readable: the nibbles and `ccs_rx_byte` keep their values. The output stream is unaffected.
- R9: With `ccs_en`=1, the output drives only timeslot 16. It carries `ccs_tx_byte` bit 7 first, with the byte taken at the clock edge that starts timeslot 16. Every other period has `sig_oe`=0.
- R10: With `ccs_en`=1, the 8 bits received in timeslot 16 are loaded into `ccs_rx_byte` at the end of the frame, with the first bit received becoming bit 7. The nibbles stay unchanged. `ccs_rx_byte` changes only in this mode.
- R11: `half_sel_hi`, `serial_off` and `ccs_en` are taken at the clock edge that starts a frame. A change in the middle of a frame first acts in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one period per bit |
| rst | input | 1 | Synchronous reset, active high |
| fp_n | input | 1 | Frame pulse, active low, one period long |
| half_sel_hi | input | 1 | 1: nibble in bit periods 0-3; 0: in bit periods 4-7 |
| serial_off | input | 1 | 1: serial input has no effect |
| ccs_en | input | 1 | 1: 64 kb/s timeslot-16 stream instead of nibbles |
| ln_we | input | 1 | Write strobe for the outgoing nibble store |
| ln_ch | input | 5 | Channel written (0 to 29) |
| ln_nib | input | 4 | Nibble written |
| ccs_tx_byte | input | 8 | Byte sent in timeslot 16 in common-channel mode |
| sig_i | input | 1 | Incoming serial stream |
| sig_o | output | 1 | Outgoing serial stream |
| sig_oe | output | 1 | 1 where `sig_o` is driven, 0 where high-impedance |
| rd_ch | input | 5 | Channel read (0 to 29) |
| rd_nib | output | 4 | Readable captured nibble of `rd_ch` |
| ccs_rx_byte | output | 8 | Timeslot-16 byte of the last captured common-channel frame |

## Verification
Every bit period of several whole frames is compared against an arithmetic model, in both half selections and in common-channel mode. This separates timeslot-to-channel mapping errors from bit-order errors and from drive-enable errors in the unselected half. Incoming frames carry deliberate noise in the ignored half and in timeslots 0 and 16, so a wrong half or a capture in a reserved timeslot changes the read-back. A frame with the bypass set, a common-channel frame, a truncated frame and a mid-frame change of the half select each show whether the readable nibbles move when they should stay. A mid-frame read of channel 0 separates a frame-end hand-over from writing in place.

// File: rtl/sigstr_pkg.sv
package sigstr_pkg;

  typedef struct packed {
    logic hi;
    logic off;
    logic ccs;
  } sig_mode_t;

  // timeslot carries a signalling nibble
  function automatic logic slot_is_cas(input int ts, input int ccs_slot);
    return (ts != 0) && (ts != ccs_slot);
  endfunction

  // channel index of a signalling timeslot, 0 for reserved ones
  function automatic int chan_of_slot(input int ts, input int ccs_slot);
    if (ts == 0 || ts == ccs_slot) return 0;
    return (ts < ccs_slot) ? ts - 1 : ts - 2;
  endfunction

endpackage

// File: rtl/sigstr_frame_timer.sv
module sigstr_frame_timer
  import sigstr_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           fp_n,
  input  sig_mode_t                      mode_d,
  output logic [$clog2(SLOTS*BITS)-1:0]  cnt,
  output logic [$clog2(SLOTS*BITS)-1:0]  nxt,
  output logic                           synced,
  output sig_mode_t                      mode_q
);
  localparam int CW = $clog2(SLOTS*BITS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS*BITS-1);

  always_comb begin
    if (!fp_n || cnt == LAST) nxt = '0;
    else                      nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      synced <= 1'b0;
      mode_q <= '0;
    end else begin
      cnt <= nxt;
      if (!fp_n) synced <= 1'b1;
      if (nxt == '0) mode_q <= mode_d;
    end
  end

  // R2
  pulse_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !fp_n |=> cnt == '0);
  // R2
  period_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_n && cnt != LAST) |=> cnt == $past(cnt) + CW'(1));

endmodule

// File: rtl/sigstr_ser.sv
module sigstr_ser
  import sigstr_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int BITS     = 8,
  parameter int CHANS    = 30,
  parameter int NIB      = 4,
  parameter int CCS_SLOT = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(SLOTS)-1:0]       ts_cur,
  input  logic [$clog2(SLOTS*BITS)-1:0]  nxt,
  input  logic                           synced,
  input  logic                           hi_sel,
  input  logic                           ccs_on,
  input  logic                           ln_we,
  input  logic [$clog2(CHANS)-1:0]       ln_ch,
  input  logic [NIB-1:0]                 ln_nib,
  input  logic [BITS-1:0]                ccs_byte,
  output logic                           sig_o,
  output logic                           sig_oe
);
  localparam int BW  = $clog2(BITS);
  localparam int CW  = $clog2(SLOTS*BITS);
  localparam int TW  = CW - BW;
  localparam int CHW = $clog2(CHANS);
  localparam int NBW = $clog2(NIB);

  logic [NIB-1:0]  nib_mem [CHANS];
  logic [NIB-1:0]  mem_q, nib_hold, nib_cur;
  logic [BITS-1:0] ccs_hold, byte_cur;
  logic [TW-1:0]   ts_ahead, ts_n;
  logic [BW-1:0]   bit_n;
  logic [CHW-1:0]  ahead_ch;
  logic            oe_n, d_n, upper_n;

  assign ts_ahead = ts_cur + TW'(1);
  assign ahead_ch = CHW'(chan_of_slot(int'(ts_ahead), CCS_SLOT));
  assign ts_n     = nxt[CW-1:BW];
  assign bit_n    = nxt[BW-1:0];
  assign upper_n  = bit_n < BW'(NIB);

  // line-side store, synchronous read one timeslot ahead
  always_ff @(posedge clk) begin
    if (ln_we) nib_mem[ln_ch] <= ln_nib;
  end

  always_ff @(posedge clk) begin
    mem_q <= nib_mem[ahead_ch];
  end

  assign nib_cur  = (bit_n == '0) ? mem_q    : nib_hold;
  assign byte_cur = (bit_n == '0) ? ccs_byte : ccs_hold;

  always_comb begin
    if (!synced)     oe_n = 1'b0;
    else if (ccs_on) oe_n = (ts_n == TW'(CCS_SLOT));
    else             oe_n = slot_is_cas(int'(ts_n), CCS_SLOT) && (upper_n == hi_sel);
    d_n = ccs_on ? byte_cur[~bit_n] : nib_cur[~bit_n[NBW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_hold <= '0;
      ccs_hold <= '0;
      sig_oe   <= 1'b0;
      sig_o    <= 1'b0;
    end else begin
      if (bit_n == '0) begin
        nib_hold <= mem_q;
        ccs_hold <= ccs_byte;
      end
      sig_oe <= oe_n;
      sig_o  <= oe_n & d_n;
    end
  end

  // R5
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sig_oe |-> !sig_o);

endmodule

// File: rtl/sigstr_des.sv
module sigstr_des
  import sigstr_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int BITS     = 8,
  parameter int CHANS    = 30,
  parameter int NIB      = 4,
  parameter int CCS_SLOT = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(SLOTS*BITS)-1:0]  cnt,
  input  logic                           synced,
  input  sig_mode_t                      mode,
  input  logic                           sig_i,
  input  logic [$clog2(CHANS)-1:0]       rd_ch,
  output logic [NIB-1:0]                 rd_nib,
  output logic [BITS-1:0]                ccs_rx
);
  localparam int BW  = $clog2(BITS);
  localparam int CW  = $clog2(SLOTS*BITS);
  localparam int TW  = CW - BW;
  localparam int CHW = $clog2(CHANS);
  localparam int AW  = $clog2(2*CHANS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS*BITS-1);

  logic [NIB-1:0]  buf_mem [2*CHANS];
  logic [BITS-2:0] sh;
  logic [BITS-1:0] byte_now, ccs_stage;
  logic [NIB-1:0]  nib_sel;
  logic [TW-1:0]   ts_c;
  logic [CHW-1:0]  ch_c;
  logic [AW-1:0]   wr_addr, rd_addr;
  logic            bank, last_bit, take, wr_en, commit;

  assign ts_c     = cnt[CW-1:BW];
  assign last_bit = cnt[BW-1:0] == BW'(BITS-1);
  assign byte_now = {sh, sig_i};
  assign nib_sel  = mode.hi ? byte_now[BITS-1 -: NIB] : byte_now[NIB-1:0];
  assign ch_c     = CHW'(chan_of_slot(int'(ts_c), CCS_SLOT));
  assign take     = synced && !mode.off;
  assign wr_en    = take && last_bit && !mode.ccs && slot_is_cas(int'(ts_c), CCS_SLOT);
  assign commit   = take && (cnt == LAST);
  // capture half selected by bank, readers see the other half
  assign wr_addr  = bank ? AW'(CHANS) + AW'(ch_c)  : AW'(ch_c);
  assign rd_addr  = bank ? AW'(rd_ch)              : AW'(CHANS) + AW'(rd_ch);

  always_ff @(posedge clk) begin
    if (wr_en) buf_mem[wr_addr] <= nib_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bank      <= 1'b0;
      ccs_stage <= '0;
      ccs_rx    <= '0;
      rd_nib    <= '0;
    end else begin
      sh     <= byte_now[BITS-2:0];
      rd_nib <= buf_mem[rd_addr];
      if (take && last_bit && mode.ccs && ts_c == TW'(CCS_SLOT))
        ccs_stage <= byte_now;
      if (commit) begin
        if (mode.ccs) ccs_rx <= ccs_stage;
        else          bank   <= ~bank;
      end
    end
  end

  // R8
  bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode.off && cnt == LAST) |=> bank == $past(bank));
  // R10
  ccs_byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mode.ccs |=> ccs_rx == $past(ccs_rx));
  // R7
  mid_frame_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> bank == $past(bank));

endmodule

// File: rtl/sigstr_cas_if.sv
module sigstr_cas_if
  import sigstr_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int BITS     = 8,
  parameter int CHANS    = 30,
  parameter int NIB      = 4,
  parameter int CCS_SLOT = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fp_n,
  input  logic                      half_sel_hi,
  input  logic                      serial_off,
  input  logic                      ccs_en,
  input  logic                      ln_we,
  input  logic [$clog2(CHANS)-1:0]  ln_ch,
  input  logic [NIB-1:0]            ln_nib,
  input  logic [BITS-1:0]           ccs_tx_byte,
  input  logic                      sig_i,
  output logic                      sig_o,
  output logic                      sig_oe,
  input  logic [$clog2(CHANS)-1:0]  rd_ch,
  output logic [NIB-1:0]            rd_nib,
  output logic [BITS-1:0]           ccs_rx_byte
);
  localparam int BW = $clog2(BITS);
  localparam int CW = $clog2(SLOTS*BITS);
  localparam int TW = CW - BW;

  logic [CW-1:0] cnt, nxt;
  logic          synced;
  sig_mode_t     mode_d, mode_q;

  assign mode_d = '{hi: half_sel_hi, off: serial_off, ccs: ccs_en};

  sigstr_frame_timer #(.SLOTS(SLOTS), .BITS(BITS)) u_timer (
    .clk(clk), .rst(rst), .fp_n(fp_n), .mode_d(mode_d),
    .cnt(cnt), .nxt(nxt), .synced(synced), .mode_q(mode_q)
  );

  sigstr_ser #(.SLOTS(SLOTS), .BITS(BITS), .CHANS(CHANS), .NIB(NIB), .CCS_SLOT(CCS_SLOT)) u_ser (
    .clk(clk), .rst(rst), .ts_cur(cnt[CW-1:BW]), .nxt(nxt), .synced(synced),
    .hi_sel(mode_q.hi), .ccs_on(mode_q.ccs),
    .ln_we(ln_we), .ln_ch(ln_ch), .ln_nib(ln_nib), .ccs_byte(ccs_tx_byte),
    .sig_o(sig_o), .sig_oe(sig_oe)
  );

  sigstr_des #(.SLOTS(SLOTS), .BITS(BITS), .CHANS(CHANS), .NIB(NIB), .CCS_SLOT(CCS_SLOT)) u_des (
    .clk(clk), .rst(rst), .cnt(cnt), .synced(synced), .mode(mode_q),
    .sig_i(sig_i), .rd_ch(rd_ch), .rd_nib(rd_nib), .ccs_rx(ccs_rx_byte)
  );

  // R1
  no_drive_unsynced_chk: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !sig_oe);
  // R3
  slot_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt[CW-1:BW] == '0) |-> !sig_oe);
  // R4
  low_half_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.ccs && mode_q.hi && cnt[BW-1:0] >= BW'(NIB)) |-> !sig_oe);
  // R4
  high_half_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.ccs && !mode_q.hi && cnt[BW-1:0] < BW'(NIB)) |-> !sig_oe);
  // R9
  ccs_only_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q.ccs && cnt[CW-1:BW] != TW'(CCS_SLOT)) |-> !sig_oe);

endmodule

// File: tb/tb_sigstr_cas_if.sv
module tb_sigstr_cas_if;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fp_n = 1'b1;
  logic       half_sel_hi = 1'b0, serial_off = 1'b0, ccs_en = 1'b0;
  logic       ln_we = 1'b0;
  logic [4:0] ln_ch = '0;
  logic [3:0] ln_nib = '0;
  logic [7:0] ccs_tx_byte = '0;
  logic       sig_i = 1'b0;
  logic       sig_o, sig_oe;
  logic [4:0] rd_ch = '0;
  logic [3:0] rd_nib;
  logic [7:0] ccs_rx_byte;

  sigstr_cas_if dut (
    .clk(clk), .rst(rst), .fp_n(fp_n), .half_sel_hi(half_sel_hi),
    .serial_off(serial_off), .ccs_en(ccs_en), .ln_we(ln_we), .ln_ch(ln_ch),
    .ln_nib(ln_nib), .ccs_tx_byte(ccs_tx_byte), .sig_i(sig_i), .sig_o(sig_o),
    .sig_oe(sig_oe), .rd_ch(rd_ch), .rd_nib(rd_nib), .ccs_rx_byte(ccs_rx_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0, committed = 1'b0;
  logic [3:0] lnv [30];
  logic [3:0] txv [30];
  logic [7:0] ccs_exp = '0;

  function automatic logic [7:0] in_byte(input int ts, input int seed);
    return 8'(((ts * 37) + (seed * 91) + 13) ^ (seed * 16));
  endfunction

  function automatic int slot_of(input int c);
    return (c < 15) ? c + 1 : c + 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic load_ln(input int base);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      ln_we  = 1'b1;
      ln_ch  = 5'(c);
      ln_nib = 4'((c * 5 + base) % 16);
      lnv[c] = 4'((c * 5 + base) % 16);
    end
    @(negedge clk);
    ln_we = 1'b0;
  endtask

  // one frame: hi/off/ccs are the values latched at the pulse
  task automatic run_frame(input bit hi, input bit off, input bit ccs, input logic [7:0] ctx,
                           input int seed, input int nbits, input int flip_at);
    @(negedge clk);
    half_sel_hi = hi; serial_off = off; ccs_en = ccs; ccs_tx_byte = ctx;
    fp_n = 1'b0; rd_ch = '0;
    for (int k = 0; k < nbits; k++) begin
      int ts, bn, ch;
      bit exp_oe, exp_d, late;
      logic [7:0] b;
      @(negedge clk);
      if (k == 0) fp_n = 1'b1;
      ts = k / 8; bn = k % 8;
      ch = (ts < 16) ? ts - 1 : ts - 2;
      late = (flip_at >= 0) && (k > flip_at);
      if (ccs) begin
        exp_oe = (ts == 16);
        exp_d  = exp_oe ? ctx[7-bn] : 1'b0;
      end else begin
        exp_oe = (ts != 0) && (ts != 16) && ((bn < 4) == hi);
        exp_d  = exp_oe ? lnv[ch][3-(bn%4)] : 1'b0;
      end
      if (late)
        chk(sig_oe === exp_oe, "R11", int'(sig_oe), int'(exp_oe));
      else if (ccs)
        chk(sig_oe === exp_oe, "R9", int'(sig_oe), int'(exp_oe));
      else if (ts == 0 || ts == 16)
        chk(sig_oe === exp_oe, "R3", int'(sig_oe), int'(exp_oe));
      else
        chk(sig_oe === exp_oe, "R4", int'(sig_oe), int'(exp_oe));
      if (!exp_oe)
        chk(sig_o === 1'b0, "R5", int'(sig_o), 0);
      else
        chk(sig_o === exp_d, "R2/R3 bit", int'(sig_o), int'(exp_d));
      if (k == 250 && committed)
        chk(rd_nib === txv[0], "R7 mid-frame", int'(rd_nib), int'(txv[0]));
      if (k == flip_at) half_sel_hi = ~hi;
      b = in_byte(ts, seed);
      sig_i = b[7-bn];
    end
    if (nbits == 256 && !off) begin
      if (ccs) ccs_exp = in_byte(16, seed);
      else begin
        for (int c = 0; c < 30; c++) begin
          logic [7:0] bb;
          bb = in_byte(slot_of(c), seed);
          txv[c] = hi ? bb[7:4] : bb[3:0];
        end
        committed = 1'b1;
      end
    end
  endtask

  task automatic read_back(input string req);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      rd_ch = 5'(c);
      @(negedge clk);
      chk(rd_nib === txv[c], req, int'(rd_nib), int'(txv[c]));
    end
    chk(ccs_rx_byte === ccs_exp, req, int'(ccs_rx_byte), int'(ccs_exp));
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(sig_oe === 1'b0, "R1", int'(sig_oe), 0);
    chk(sig_o === 1'b0, "R1", int'(sig_o), 0);
    chk(ccs_rx_byte === 8'h00, "R1", int'(ccs_rx_byte), 0);
    rst = 1'b0;
    // R1 no drive before first pulse
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk(sig_oe === 1'b0, "R1 unsynced", int'(sig_oe), 0);
    end
    load_ln(3);
    run_frame(1'b1, 1'b0, 1'b0, 8'h00, 1, 256, -1);
    read_back("R6 upper half");
    run_frame(1'b0, 1'b0, 1'b0, 8'h00, 2, 256, 100);   // R11 flip mid-frame
    read_back("R6 lower half");
    load_ln(9);
    run_frame(1'b1, 1'b1, 1'b0, 8'h00, 3, 256, -1);
    read_back("R8 bypass");
    run_frame(1'b1, 1'b0, 1'b1, 8'hA5, 4, 256, -1);
    read_back("R10 ccs capture");
    run_frame(1'b0, 1'b1, 1'b1, 8'h3C, 5, 256, -1);
    read_back("R8 ccs bypass");
    run_frame(1'b0, 1'b0, 1'b0, 8'h00, 6, 256, -1);
    read_back("R6 second pattern");
    run_frame(1'b1, 1'b0, 1'b0, 8'h00, 7, 120, -1);
    read_back("R7 cut frame");
    done = 1'b1;
    report();
    $finish;
  end

endmodule